// File: doc/BRIEF.md
# Burst-of-Two Separate-Port SRAM Core

This block models a static memory that has a read port and a write port running side by side, each moving exactly two words per command. One internal clock runs at twice the command rate. A phase bit splits it into command edges (the rising edge of K) and mid-cycle edges (the rising edge of K#). A single address bus carries the read address on command edges and the write address on mid-cycle edges.

Writes use early-data timing. The first data word and its lane enables arrive with the write command. The write address, the second word and its enables arrive half a cycle later. A finished write waits in a one-entry buffer and is copied into the array only while the next write command is being accepted. Reads look through any write still being assembled, then through the buffer, then into the array, one byte lane at a time. A read therefore returns the newest data even when that data has not reached the array yet.

Read data comes out 1.5 and 2 cycles after the command. It is qualified by a valid flag and by an output-enable flag that marks when the data pins would be driven.

Top module: `bt2_sram`

## Requirements
- R1: `kph` is low after reset. It toggles on every clock edge, so it reads high after each command (K) edge and low after each mid-cycle (K#) edge. The first edge after reset is a command edge.
- R2: During reset and after it, `rvalid`, `oe` and `rdata` are all zero. The write buffer is empty, and every location reads as zero until it is written.
- R3: A read is accepted when `rd_n` is low on a command edge, and `addr` is its address A. The word at A appears on the mid-cycle edge 1.5 cycles later and the word at A+1 on the command edge that follows. `rvalid` and `oe` are high for both words.
- R4: The second address of every burst is A+1 modulo 2^ADDR_W, so address 2^ADDR_W-1 is followed by address 0.
- R5: A write is accepted when `wr_n` is low on a command edge. `wdata` and `wbe_n` on that edge give the word for A. On the next mid-cycle edge, `addr` gives A, and `wdata` and `wbe_n` give the word for A+1.
- R6: `wbe_n` is active low, with one bit per 9-bit lane; bit 0 controls `wdata[8:0]` and bit 1 controls `wdata[17:9]`. Each of the two burst words has its own enables. A lane whose enable is high is left unchanged, so a write with every enable high changes nothing.
- R7: A completed write stays in the buffer until the next write command. A read of a buffered address returns the buffered data.
- R8: A read returns the data of a write issued in the same cycle or in the next cycle when that write touches the read's addresses.
- R9: A cycle with `rd_n` high does not cancel a read already accepted. On any output edge with no read word due, `rvalid` and `oe` are low and `rdata` is zero.
- R10: Reads and writes may be issued in the same cycle and in every cycle. Back-to-back reads produce unbroken valid data.
- R11: A lane whose enable was inactive in a newer write or buffered write is read from the next older source: the older buffer contents, or else the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_n | input | 1 | Read command, active low, sampled on command edges |
| wr_n | input | 1 | Write command, active low, sampled on command edges |
| addr | input | ADDR_W | Read address on command edges, write address on mid-cycle edges |
| wdata | input | LANES*LANE_W | Write data: first word on command edges, second word on mid-cycle edges |
| wbe_n | input | LANES | Active-low lane write enables, one per data word |
| kph | output | 1 | Phase: high when the next edge is a mid-cycle edge |
| rdata | output | LANES*LANE_W | Read data word, zero when not driven |
| rvalid | output | 1 | Read data qualifier |
| oe | output | 1 | Output drive enable; low means high impedance |

## Verification
A stale or wrong buffer entry shows up as one wrong lane in a read word. It appears 1.5 or 2 cycles after the read command that touched the buffered address, so the bench follows every write with reads to the same and neighbouring addresses within a cycle or two. A phase slip or a read-pipeline shift error appears on the very next edge as a `kph` mismatch or as `rvalid` on the wrong edge. A late commit, or a commit that skips a lane, stays hidden while the data sits in the buffer. It only shows once a later write moves that data into the array and a read falls through to it. The bench therefore mixes masked writes with long random command streams over a sixteen-word array.

// File: rtl/bt2_pkg.sv
package bt2_pkg;
   typedef enum logic {
      PH_K  = 1'b0,
      PH_KB = 1'b1
   } bt2_phase_e;
endpackage

// File: rtl/bt2_array.sv
module bt2_array #(
   parameter int ADDR_W    = 4,
   parameter int LANES     = 2,
   parameter int LANE_W    = 9,
   parameter int RST_CLEAR = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:0]        wa,
   input  logic [LANES*LANE_W-1:0]  wd,
   input  logic [LANES-1:0]         wen,
   input  logic [ADDR_W-1:0]        ra,
   output logic [LANES*LANE_W-1:0]  rd
);
   localparam int DEPTH  = 1 << ADDR_W;
   localparam int WORD_W = LANES * LANE_W;

   logic [WORD_W-1:0] mem [DEPTH];

   generate
      if (RST_CLEAR != 0) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               for (int l = 0; l < LANES; l++)
                  if (wen[l]) mem[wa][l*LANE_W +: LANE_W] <= wd[l*LANE_W +: LANE_W];
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) begin
               for (int l = 0; l < LANES; l++)
                  if (wen[l]) mem[wa][l*LANE_W +: LANE_W] <= wd[l*LANE_W +: LANE_W];
            end
         end
      end
   endgenerate

   assign rd = mem[ra];
endmodule

// File: rtl/bt2_wbuf.sv
module bt2_wbuf
   import bt2_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  bt2_phase_e               ph,
   input  logic                     wr_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic [LANES-1:0]         wbe_n,
   // commit port toward the array
   output logic                     aw_we,
   output logic [ADDR_W-1:0]        aw_a,
   output logic [LANES*LANE_W-1:0]  aw_d,
   output logic [LANES-1:0]         aw_en,
   // write being assembled on this edge
   output logic                     nw_v,
   output logic [ADDR_W-1:0]        nw_a0,
   output logic [ADDR_W-1:0]        nw_a1,
   output logic [LANES*LANE_W-1:0]  nw_d0,
   output logic [LANES*LANE_W-1:0]  nw_d1,
   output logic [LANES-1:0]         nw_e0,
   output logic [LANES-1:0]         nw_e1,
   // buffered write
   output logic                     bf_v,
   output logic [ADDR_W-1:0]        bf_a0,
   output logic [ADDR_W-1:0]        bf_a1,
   output logic [LANES*LANE_W-1:0]  bf_d0,
   output logic [LANES*LANE_W-1:0]  bf_d1,
   output logic [LANES-1:0]         bf_e0,
   output logic [LANES-1:0]         bf_e1
);
   localparam int WORD_W = LANES * LANE_W;

   logic              k_edge;
   logic              stg_v;
   logic [WORD_W-1:0] stg_d;
   logic [LANES-1:0]  stg_e;
   logic              buf_v;
   logic [ADDR_W-1:0] buf_a;
   logic [WORD_W-1:0] buf_d0, buf_d1;
   logic [LANES-1:0]  buf_e0, buf_e1;

   assign k_edge = (ph == PH_K);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_v  <= 1'b0;
         stg_d  <= '0;
         stg_e  <= '0;
         buf_v  <= 1'b0;
         buf_a  <= '0;
         buf_d0 <= '0;
         buf_d1 <= '0;
         buf_e0 <= '0;
         buf_e1 <= '0;
      end else if (k_edge) begin
         stg_v <= !wr_n;
         if (!wr_n) begin
            stg_d <= wdata;
            stg_e <= ~wbe_n;
         end
      end else begin
         stg_v <= 1'b0;
         if (stg_v) begin
            buf_v  <= 1'b1;
            buf_a  <= addr;
            buf_d0 <= stg_d;
            buf_d1 <= wdata;
            buf_e0 <= stg_e;
            buf_e1 <= ~wbe_n;
         end
      end
   end

   // old buffer drains one word per edge while a new write is accepted
   always_comb begin
      aw_we = buf_v && (k_edge ? !wr_n : stg_v);
      aw_a  = k_edge ? buf_a  : buf_a + ADDR_W'(1);
      aw_d  = k_edge ? buf_d0 : buf_d1;
      aw_en = k_edge ? buf_e0 : buf_e1;
   end

   assign nw_v  = stg_v && !k_edge;
   assign nw_a0 = addr;
   assign nw_a1 = addr + ADDR_W'(1);
   assign nw_d0 = stg_d;
   assign nw_d1 = wdata;
   assign nw_e0 = stg_e;
   assign nw_e1 = ~wbe_n;

   assign bf_v  = buf_v;
   assign bf_a0 = buf_a;
   assign bf_a1 = buf_a + ADDR_W'(1);
   assign bf_d0 = buf_d0;
   assign bf_d1 = buf_d1;
   assign bf_e0 = buf_e0;
   assign bf_e1 = buf_e1;

   // R5
   stg_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stg_v |-> (ph == PH_KB));

   // R7
   buf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_v |=> buf_v);
endmodule

// File: rtl/bt2_rdpipe.sv
module bt2_rdpipe
   import bt2_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int LANES  = 2,
   parameter int LANE_W = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  bt2_phase_e               ph,
   input  logic                     rd_n,
   input  logic [ADDR_W-1:0]        addr,
   output logic [ADDR_W-1:0]        arr_ra,
   input  logic [LANES*LANE_W-1:0]  arr_rd,
   input  logic                     nw_v,
   input  logic [ADDR_W-1:0]        nw_a0,
   input  logic [ADDR_W-1:0]        nw_a1,
   input  logic [LANES*LANE_W-1:0]  nw_d0,
   input  logic [LANES*LANE_W-1:0]  nw_d1,
   input  logic [LANES-1:0]         nw_e0,
   input  logic [LANES-1:0]         nw_e1,
   input  logic                     bf_v,
   input  logic [ADDR_W-1:0]        bf_a0,
   input  logic [ADDR_W-1:0]        bf_a1,
   input  logic [LANES*LANE_W-1:0]  bf_d0,
   input  logic [LANES*LANE_W-1:0]  bf_d1,
   input  logic [LANES-1:0]         bf_e0,
   input  logic [LANES-1:0]         bf_e1,
   output logic [LANES*LANE_W-1:0]  rdata_o,
   output logic                     rvalid_o,
   output logic                     oe_o
);
   localparam int WORD_W = LANES * LANE_W;

   logic              s1_v, s2_v;
   logic [ADDR_W-1:0] s1_a, s2_a;
   logic [ADDR_W-1:0] sel_a;
   logic              hn0, hn1, hb0, hb1;
   logic [WORD_W-1:0] merged;

   // mid-cycle edge drives the first word, command edge the second
   assign sel_a  = (ph == PH_KB) ? s2_a : s2_a + ADDR_W'(1);
   assign arr_ra = sel_a;

   assign hn0 = nw_v && (nw_a0 == sel_a);
   assign hn1 = nw_v && (nw_a1 == sel_a);
   assign hb0 = bf_v && (bf_a0 == sel_a);
   assign hb1 = bf_v && (bf_a1 == sel_a);

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         localparam int LO = l * LANE_W;
         assign merged[LO +: LANE_W] =
            (hn0 && nw_e0[l]) ? nw_d0[LO +: LANE_W] :
            (hn1 && nw_e1[l]) ? nw_d1[LO +: LANE_W] :
            (hb0 && bf_e0[l]) ? bf_d0[LO +: LANE_W] :
            (hb1 && bf_e1[l]) ? bf_d1[LO +: LANE_W] :
                                arr_rd[LO +: LANE_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v     <= 1'b0;
         s1_a     <= '0;
         s2_v     <= 1'b0;
         s2_a     <= '0;
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
         oe_o     <= 1'b0;
      end else begin
         if (ph == PH_K) begin
            s1_v <= !rd_n;
            s1_a <= addr;
            s2_v <= s1_v;
            s2_a <= s1_a;
         end
         rvalid_o <= s2_v;
         oe_o     <= s2_v;
         rdata_o  <= s2_v ? merged : '0;
      end
   end

   // R3
   rd_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid_o) |-> (ph == PH_K));

   // R3
   burst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rvalid_o && (ph == PH_K)) |=> rvalid_o);
endmodule

// File: rtl/bt2_sram.sv
module bt2_sram
   import bt2_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter int LANES     = 2,
   parameter int LANE_W    = 9,
   parameter int RST_CLEAR = 1,
   localparam int WORD_W   = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [LANES-1:0]  wbe_n,
   output logic              kph,
   output logic [WORD_W-1:0] rdata,
   output logic              rvalid,
   output logic              oe
);
   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_aw
         $error("bt2_sram: ADDR_W must lie in 1..10");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("bt2_sram: LANES and LANE_W must be positive");
      end
   endgenerate

   bt2_phase_e ph;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             ph <= PH_K;
      else if (ph == PH_K)    ph <= PH_KB;
      else                    ph <= PH_K;
   end

   assign kph = (ph == PH_KB);

   logic              aw_we;
   logic [ADDR_W-1:0] aw_a, arr_ra;
   logic [WORD_W-1:0] aw_d, arr_rd;
   logic [LANES-1:0]  aw_en;
   logic              nw_v, bf_v;
   logic [ADDR_W-1:0] nw_a0, nw_a1, bf_a0, bf_a1;
   logic [WORD_W-1:0] nw_d0, nw_d1, bf_d0, bf_d1;
   logic [LANES-1:0]  nw_e0, nw_e1, bf_e0, bf_e1;

   bt2_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .ph(ph), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .wbe_n(wbe_n),
      .aw_we(aw_we), .aw_a(aw_a), .aw_d(aw_d), .aw_en(aw_en),
      .nw_v(nw_v), .nw_a0(nw_a0), .nw_a1(nw_a1), .nw_d0(nw_d0), .nw_d1(nw_d1),
      .nw_e0(nw_e0), .nw_e1(nw_e1),
      .bf_v(bf_v), .bf_a0(bf_a0), .bf_a1(bf_a1), .bf_d0(bf_d0), .bf_d1(bf_d1),
      .bf_e0(bf_e0), .bf_e1(bf_e1)
   );

   bt2_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W),
               .RST_CLEAR(RST_CLEAR)) u_array (
      .clk(clk), .rst_n(rst_n), .we(aw_we), .wa(aw_a), .wd(aw_d),
      .wen(aw_en), .ra(arr_ra), .rd(arr_rd)
   );

   bt2_rdpipe #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rdpipe (
      .clk(clk), .rst_n(rst_n), .ph(ph), .rd_n(rd_n), .addr(addr),
      .arr_ra(arr_ra), .arr_rd(arr_rd),
      .nw_v(nw_v), .nw_a0(nw_a0), .nw_a1(nw_a1), .nw_d0(nw_d0), .nw_d1(nw_d1),
      .nw_e0(nw_e0), .nw_e1(nw_e1),
      .bf_v(bf_v), .bf_a0(bf_a0), .bf_a1(bf_a1), .bf_d0(bf_d0), .bf_d1(bf_d1),
      .bf_e0(bf_e0), .bf_e1(bf_e1),
      .rdata_o(rdata), .rvalid_o(rvalid), .oe_o(oe)
   );
endmodule

// File: tb/tb_bt2_sram.sv
module tb_bt2_sram;
   localparam int CLK_P = 10;
   localparam int AW    = 4;
   localparam int NL    = 2;
   localparam int LW    = 9;
   localparam int WW    = NL * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rd_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [WW-1:0] wdata = '0;
   logic [NL-1:0] wbe_n = '1;
   logic          kph, rvalid, oe;
   logic [WW-1:0] rdata;

   bt2_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .RST_CLEAR(1)) dut (
      .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
      .wdata(wdata), .wbe_n(wbe_n), .kph(kph), .rdata(rdata),
      .rvalid(rvalid), .oe(oe)
   );

   always #(CLK_P/2) clk = ~clk;

   int            nvec = 0;
   int            nbad = 0;
   bit            done = 1'b0;
   logic [WW-1:0] refm [DEPTH];
   bit            pv1 = 1'b0, pv2 = 1'b0;
   logic [AW-1:0] pa1 = '0;
   logic [WW-1:0] e1 = '0;
   string         t1 = "R3", t2 = "R3";
   string         tnop = "R9";
   logic [31:0]   seed = 32'h1234_5678;

   function automatic logic [31:0] rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed;
   endfunction

   function automatic logic [WW-1:0] pat(input int a, input int n);
      return WW'((a * 131 + n * 977 + 5) ^ (n << 11));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic put(input logic [AW-1:0] a, input logic [WW-1:0] d, input logic [NL-1:0] bn);
      for (int l = 0; l < NL; l++)
         if (!bn[l]) refm[a][l*LW +: LW] = d[l*LW +: LW];
   endtask

   // one command cycle: command edge then mid-cycle edge
   task automatic cyc(input bit rd, input bit wr, input logic [AW-1:0] ra,
                      input logic [AW-1:0] wa, input logic [WW-1:0] d0,
                      input logic [NL-1:0] b0, input logic [WW-1:0] d1,
                      input logic [NL-1:0] b1, input string tag);
      logic [AW-1:0] nx;
      string tg;
      @(negedge clk);
      rd_n = !rd; wr_n = !wr; addr = ra; wdata = d0; wbe_n = b0;
      @(posedge clk); #1;
      chk("R1", 32'(kph), 32'd1);
      tg = pv2 ? t2 : tnop;
      chk(tg, 32'(rvalid), 32'(pv2));
      chk(tg, 32'(oe), 32'(pv2));
      chk(tg, 32'(rdata), pv2 ? 32'(e1) : 32'd0);
      @(negedge clk);
      addr = wa; wdata = d1; wbe_n = b1;
      if (wr) begin
         put(wa, d0, b0);
         nx = wa + AW'(1);
         put(nx, d1, b1);
      end
      @(posedge clk); #1;
      chk("R1", 32'(kph), 32'd0);
      tg = pv1 ? t1 : tnop;
      chk(tg, 32'(rvalid), 32'(pv1));
      chk(tg, 32'(oe), 32'(pv1));
      chk(tg, 32'(rdata), pv1 ? 32'(refm[pa1]) : 32'd0);
      nx  = pa1 + AW'(1);
      pv2 = pv1; t2 = t1; e1 = refm[nx];
      pv1 = rd; pa1 = ra; t1 = tag;
   endtask

   task automatic nop(input string tag);
      cyc(1'b0, 1'b0, '0, '0, '0, '1, '0, '1, tag);
   endtask

   task automatic rdc(input logic [AW-1:0] a, input string tag);
      cyc(1'b1, 1'b0, a, '0, '0, '1, '0, '1, tag);
   endtask

   task automatic wrc(input logic [AW-1:0] a, input logic [WW-1:0] d0, input logic [NL-1:0] b0,
                      input logic [WW-1:0] d1, input logic [NL-1:0] b1, input string tag);
      cyc(1'b0, 1'b1, '0, a, d0, b0, d1, b1, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nbad++;
         $display("FAIL R3 watchdog act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) refm[i] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R2 reset state
      chk("R2", 32'(rvalid), 32'd0);
      chk("R2", 32'(oe), 32'd0);
      chk("R2", 32'(rdata), 32'd0);
      chk("R2", 32'(kph), 32'd0);
      @(posedge clk); #1;
      rst_n = 1'b1;

      // R2 never-written locations read zero, R9 idle outputs
      rdc(4'd3, "R2");
      nop("R9");
      nop("R9");

      // R5 fill every address with full writes
      for (int a = 0; a < DEPTH; a++)
         wrc(AW'(a), pat(a, 0), 2'b00, pat(a, 1), 2'b00, "R5");

      // R3 / R10 continuous back-to-back reads of every address
      for (int a = 0; a < DEPTH; a++) rdc(AW'(a), (a % 2 == 0) ? "R3" : "R10");
      nop("R9");
      nop("R9");

      // R4 wrap of the second burst address
      wrc(AW'(DEPTH-1), pat(40, 0), 2'b00, pat(40, 1), 2'b00, "R4");
      nop("R4");
      rdc(AW'(DEPTH-1), "R4");
      nop("R4");
      nop("R4");

      // R6 every lane-enable combination on both words, including abort
      for (int m = 0; m < 16; m++) begin
         wrc(4'd5, pat(m, 2), m[1:0], pat(m, 3), m[3:2], "R6");
         nop("R6");
         rdc(4'd5, "R6");
         rdc(4'd4, "R6");
         nop("R6");
         nop("R6");
      end

      // R7 read straight from the buffer before any commit
      wrc(4'd9, pat(9, 7), 2'b00, pat(9, 8), 2'b00, "R7");
      rdc(4'd9, "R7");
      rdc(4'd10, "R7");
      rdc(4'd8, "R7");
      nop("R7");
      nop("R7");

      // R8 read followed by a write to the same addresses next cycle
      rdc(4'd2, "R8");
      wrc(4'd2, pat(2, 9), 2'b00, pat(2, 10), 2'b00, "R8");
      rdc(4'd12, "R8");
      wrc(4'd11, pat(11, 9), 2'b00, pat(11, 10), 2'b00, "R8");
      nop("R8");
      nop("R8");

      // R10 read and write issued together
      cyc(1'b1, 1'b1, 4'd6, 4'd6, pat(6, 11), 2'b00, pat(6, 12), 2'b00, "R10");
      cyc(1'b1, 1'b1, 4'd7, 4'd6, pat(6, 13), 2'b01, pat(6, 14), 2'b10, "R10");
      nop("R10");
      nop("R10");

      // R11 lane fallback through buffer and array
      wrc(4'd13, pat(13, 1), 2'b00, pat(13, 2), 2'b00, "R11");
      wrc(4'd13, pat(13, 3), 2'b10, pat(13, 4), 2'b01, "R11");
      rdc(4'd13, "R11");
      wrc(4'd14, pat(14, 5), 2'b01, pat(14, 6), 2'b10, "R11");
      rdc(4'd13, "R11");
      nop("R11");
      nop("R11");

      // R9 idle cycles between reads do not cancel reads in flight
      rdc(4'd1, "R9");
      nop("R9");
      rdc(4'd0, "R9");
      nop("R9");
      nop("R9");
      nop("R9");

      // R10 random mixed traffic
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] r0, r1, r2;
         r0 = rnd(); r1 = rnd(); r2 = rnd();
         cyc(r0[20], r0[21], r0[27:24], r1[27:24], WW'(r1), r0[5:4],
             WW'(r2), r0[9:8], "R10");
      end
      nop("R10");
      nop("R10");
      nop("R10");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end
endmodule